// File: doc/BRIEF.md
# Serially Addressed Three-State Pin Driver

This block lets a host put any one of 32 output pins into one of three drive states (driven low, driven high, or floating) using only a handful of control wires. A 5-bit pointer chooses the target pin. The host moves the pointer by pulsing a step input. Each actuation moves it forward by one, and it rolls over from the last pin back to pin 0. A separate clear input returns the pointer to pin 0. When the host raises a write strobe, the two-bit mode it presents is stored into the pin under the pointer. All other pins keep their state.

For every pin the block presents one value bit and one drive-enable bit. A chip top level can feed these straight into three-state pads. Every register runs on one system clock. The step, clear, write and mode inputs are asynchronous to that clock and are brought in through two-flop synchronizers. Strobes are then reduced to one-cycle pulses on their rising edge. The step input can come from a bouncing mechanical contact, so it also passes through a stability filter.

Top module: `tristate_pin_sequencer`

## Requirements
- R1: After reset, all pins float: `pin_oe` is all zeros, `pin_out` is all zeros, and the pointer is at pin 0.
- R2: Mode encoding on `mode_in`: 00 stores driven low (oe=1, out=0), 01 stores driven high (oe=1, out=1), and 10 or 11 stores floating (oe=0, out=0).
- R3: A write changes only the pin whose number equals the pointer. Every other bit of `pin_out` and `pin_oe` is unchanged.
- R4: Each accepted step actuation moves the pointer up by exactly one. From pin PINS-1 it moves to pin 0.
- R5: While the synchronized clear input is high, the pointer is held at 0. Clear wins over a step in the same cycle.
- R6: A new step input level is accepted only once it has held for DEBOUNCE_CYCLES consecutive clock cycles. A level held for one cycle less is ignored, and contact bounce around a single actuation advances the pointer once.
- R7: A write acts once per rising edge of `wr_in`, however long the strobe stays high. Mode changes while it stays high have no effect.
- R8: If a step and a write are accepted in the same clock cycle, the write goes to the pin the pointer selected before that step.
- R9: Step, clear, write and mode are sampled only on `clk`. None of them is used as a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_in | input | 1 | Raw pointer-advance input, may bounce |
| clr_in | input | 1 | Pointer clear, level sensitive |
| wr_in | input | 1 | Write strobe, acts on its rising edge |
| mode_in | input | 2 | Requested drive mode for the next write |
| pin_out | output | 32 | Per-pin output value |
| pin_oe | output | 32 | Per-pin drive enable (1 = driven) |

## Verification
The bench keeps PINS at 32 so that roll-over of the pointer from 31 to 0 is exercised at the real width. It sets DEBOUNCE_CYCLES to 4 so that glitches of one and two cycles, a pulse of exactly three cycles (rejected) and one of exactly four cycles (accepted) fit in short runs. The short filter also lets the step and write strobes be lined up to land in the same clock cycle. Random sequences of steps, clears and writes are compared against a bench model of the pointer and the 32 pin states.

// File: rtl/pinseq_pkg.sv
package pinseq_pkg;

  typedef struct packed {
    logic oe;
    logic val;
  } pin_drive_t;

  // bit 1 set -> floating; otherwise bit 0 is the driven level
  function automatic pin_drive_t decode_mode(input logic [1:0] mode);
    pin_drive_t d;
    d.oe  = ~mode[1];
    d.val = ~mode[1] & mode[0];
    return d;
  endfunction

endpackage

// File: rtl/pinseq_sync.sv
module pinseq_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end

endmodule

// File: rtl/pinseq_rise.sv
module pinseq_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign pulse = lvl & ~lvl_q;

  a_r7_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

endmodule

// File: rtl/pinseq_debounce.sv
module pinseq_debounce #(
  parameter int STABLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);

  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [CW-1:0] run_q, run_d;
  logic          clean_d;
  logic          differ;

  assign differ = raw ^ clean;

  always_comb begin
    run_d   = '0;
    clean_d = clean;
    if (differ) begin
      if (run_q == LAST) begin
        clean_d = raw;
        run_d   = '0;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      clean <= 1'b0;
    end else begin
      run_q <= run_d;
      clean <= clean_d;
    end
  end

  // R6: the filtered level only moves after a full stable run
  a_r6_change_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clean) |-> ($past(run_q) == LAST && $past(raw) == clean));

  a_r6_agree_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    !differ |=> run_q == '0);

endmodule

// File: rtl/pinseq_bank.sv
module pinseq_bank
  import pinseq_pkg::*;
#(
  parameter int PINS = 32,
  parameter int IW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_pulse,
  input  logic [IW-1:0]   sel,
  input  logic [1:0]      mode,
  output logic [PINS-1:0] val_q,
  output logic [PINS-1:0] oe_q
);

  pin_drive_t      req;
  logic [PINS-1:0] val_d, oe_d;

  assign req = decode_mode(mode);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic hit;
    assign hit = wr_pulse && (sel == IW'(i));

    always_comb begin
      val_d[i] = hit ? req.val : val_q[i];
      oe_d[i]  = hit ? req.oe  : oe_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      oe_q  <= '0;
    end else begin
      val_q <= val_d;
      oe_q  <= oe_d;
    end
  end

  // R3: no write, no change; a write touches at most one pin
  a_r3_quiet_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> ($stable(val_q) && $stable(oe_q)));

  a_r3_single_pin: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> ($countones((val_q ^ $past(val_q)) | (oe_q ^ $past(oe_q))) <= 1));

  // R2: a floating pin always carries value 0
  a_r2_float_low: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q & ~oe_q) == '0);

endmodule

// File: rtl/tristate_pin_sequencer.sv
module tristate_pin_sequencer #(
  parameter int PINS            = 32,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_in,
  input  logic            clr_in,
  input  logic            wr_in,
  input  logic [1:0]      mode_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);

  localparam int IW = $clog2(PINS);
  localparam logic [IW-1:0] LAST_PIN = IW'(PINS - 1);

  // reset: asserted asynchronously, released on clk
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // R9: every control is sampled data, brought in through two flops
  logic [2:0] ctl_s;
  logic [1:0] mode_s;

  pinseq_sync #(.WIDTH(3)) u_ctl_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async ({wr_in, clr_in, step_in}),
    .q_sync  (ctl_s)
  );

  pinseq_sync #(.WIDTH(2)) u_mode_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (mode_in),
    .q_sync  (mode_s)
  );

  logic step_clean, step_p, wr_p, clr_s;
  assign clr_s = ctl_s[1];

  pinseq_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_step_filt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .raw   (ctl_s[0]),
    .clean (step_clean)
  );

  pinseq_rise u_step_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl   (step_clean),
    .pulse (step_p)
  );

  pinseq_rise u_wr_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl   (ctl_s[2]),
    .pulse (wr_p)
  );

  // pin pointer
  logic [IW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr_s)       ptr_d = '0;
    else if (step_p) ptr_d = (ptr_q == LAST_PIN) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ptr_q <= '0;
    else             ptr_q <= ptr_d;
  end

  // R8: the bank sees the pointer before this cycle's step
  pinseq_bank #(.PINS(PINS), .IW(IW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_pulse (wr_p),
    .sel      (ptr_q),
    .mode     (mode_s),
    .val_q    (pin_out),
    .oe_q     (pin_oe)
  );

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_s |=> ptr_q == '0);

  a_r4_hold_without_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!step_p && !clr_s) |=> $stable(ptr_q));

  a_r4_step_moves: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_p && !clr_s) |=> !$stable(ptr_q));

endmodule

// File: tb/tb_tristate_pin_sequencer.sv
`timescale 1ns/1ps
module tb_tristate_pin_sequencer;

  localparam int PINS = 32;
  localparam int DEB  = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            step_in, clr_in, wr_in;
  logic [1:0]      mode_in;
  logic [PINS-1:0] pin_out, pin_oe;

  always #2.5 clk = ~clk;

  tristate_pin_sequencer #(.PINS(PINS), .DEBOUNCE_CYCLES(DEB)) dut (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .clr_in(clr_in),
    .wr_in(wr_in), .mode_in(mode_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [PINS-1:0] exp_val, exp_oe;
  int              exp_ptr;

  function automatic logic m_oe(input logic [1:0] m);
    return (m[1] == 1'b0);
  endfunction

  function automatic logic m_val(input logic [1:0] m);
    return (m == 2'b01);
  endfunction

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check(input string req);
    n_checks++;
    if (pin_out !== exp_val || pin_oe !== exp_oe) begin
      n_fail++;
      $display("FAIL %s: out=%h oe=%h expected out=%h oe=%h",
               req, pin_out, pin_oe, exp_val, exp_oe);
    end
  endtask

  task automatic model_write(input logic [1:0] m);
    exp_val[exp_ptr] = m_val(m);
    exp_oe[exp_ptr]  = m_oe(m);
  endtask

  task automatic do_step();
    step_in = 1'b1; wait_n(DEB + 6);
    step_in = 1'b0; wait_n(DEB + 6);
    if (clr_in == 1'b0) exp_ptr = (exp_ptr + 1) % PINS;
  endtask

  task automatic do_write(input logic [1:0] m);
    mode_in = m; wait_n(3);
    wr_in = 1'b1; wait_n(4);
    wr_in = 1'b0; wait_n(5);
    model_write(m);
  endtask

  task automatic do_clear();
    clr_in = 1'b1; wait_n(5);
    clr_in = 1'b0; wait_n(4);
    exp_ptr = 0;
  endtask

  // watchdog
  initial begin
    wait_n(150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; step_in = 0; clr_in = 0; wr_in = 0; mode_in = 2'b00;
    exp_val = '0; exp_oe = '0; exp_ptr = 0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(6);

    // R1: reset state
    check("R1 reset floats all pins");

    // R2: each encoding on pin 0; R1 pointer at 0 after reset
    do_write(2'b01); check("R1 R2 drive high at pointer 0");
    do_write(2'b00); check("R2 drive low");
    do_write(2'b11); check("R2 mode 11 floats");
    do_write(2'b01); do_write(2'b10); check("R2 mode 10 floats");

    // R3/R4: step then write touches only pin 1
    do_step(); do_write(2'b01); check("R3 R4 write pin 1 only");

    // R4: wrap from 31 to 0
    do_clear();
    for (int k = 0; k < PINS - 1; k++) do_step();
    do_write(2'b00); check("R4 pointer at pin 31");
    do_step(); do_write(2'b01); check("R4 pointer wraps to 0");

    // R5: clear held during a step keeps pointer at 0
    do_step(); do_step();
    clr_in = 1'b1; wait_n(4);
    do_step();
    clr_in = 1'b0; wait_n(4); exp_ptr = 0;
    do_write(2'b00); check("R5 clear beats step");

    // R6: 3-cycle pulse rejected, 4-cycle pulse accepted
    step_in = 1'b1; wait_n(DEB - 1); step_in = 1'b0; wait_n(DEB + 6);
    do_write(2'b11); check("R6 short pulse ignored");
    step_in = 1'b1; wait_n(DEB); step_in = 1'b0; wait_n(DEB + 6);
    exp_ptr = (exp_ptr + 1) % PINS;
    do_write(2'b01); check("R6 pulse of full length accepted");

    // R6: bouncing actuation counts once
    step_in = 1; wait_n(2); step_in = 0; wait_n(1); step_in = 1; wait_n(1);
    step_in = 0; wait_n(2); step_in = 1; wait_n(DEB + 8);
    step_in = 0; wait_n(1); step_in = 1; wait_n(2); step_in = 0; wait_n(DEB + 8);
    exp_ptr = (exp_ptr + 1) % PINS;
    do_write(2'b00); check("R6 bounce gives one step");

    // R7: long strobe with mode change while high acts once
    do_step();
    mode_in = 2'b01; wait_n(3);
    wr_in = 1'b1; wait_n(6);
    mode_in = 2'b00; wait_n(12);
    wr_in = 1'b0; wait_n(5);
    model_write(2'b01);
    check("R7 one write per strobe edge");

    // R8: step and write accepted in the same cycle
    mode_in = 2'b01; wait_n(3);
    step_in = 1'b1; wait_n(DEB);
    wr_in = 1'b1; wait_n(20);
    step_in = 1'b0; wr_in = 1'b0; wait_n(DEB + 6);
    model_write(2'b01);
    exp_ptr = (exp_ptr + 1) % PINS;
    check("R8 write uses pointer before step");
    do_write(2'b11); check("R8 R9 pointer advanced after coincident step");

    // random mix
    for (int op = 0; op < 120; op++) begin
      int sel = $urandom_range(0, 9);
      if (sel == 0) do_clear();
      else begin
        int ns = $urandom_range(0, 3);
        for (int s = 0; s < ns; s++) do_step();
      end
      do_write(2'($urandom_range(0, 3)));
      check("R2 R3 R4 random sequence");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule